// File: doc/BRIEF.md
# Byte/Word Selectable Read Port for a One-Time-Programmable Array

This block is the read side of a 16-Mbit one-time-programmable store. The store can be read as 1M entries of 16 bits or as 2M entries of 8 bits. A static organisation input picks between the two. The caller presents a 20-bit entry address, an active-low device select and an active-low output gate. The port answers on 16 data outputs, and each output has its own tri-state enable.

The top data pin has two roles. In 16-bit organisation it is data bit 15. In 8-bit organisation the pin is an input, and its level is the lowest address bit. That bit picks the lower or the upper half of the addressed entry. The chosen byte goes on the lower eight outputs, and the upper eight stay floated.

The array contents come from a synthesizable model. The model folds the address with a fixed key, so no storage is needed. All outputs are registered. Each change on the inputs shows at the pins one clock later, which stands in for access latency. While the device is deselected, the port reports standby and makes no fetch.

Top module: `otp_rd_port`

## Requirements
- R1: In 16-bit organisation with select and gate both low, `dq_o` carries the entry at address a. An entry is KEY ^ a[15:0] ^ {12'b0, a[19:16]}, with default KEY = 16'h5A3C.
- R2: With `org_word_i`=1, `sel_n_i`=0 and `gate_n_i`=0 at a clock edge, all 16 bits of `dq_oe_o` are 1 after that edge.
- R3: With `sel_n_i`=1 at a clock edge, `dq_oe_o` is all zero and `standby_o` is 1 after that edge.
- R4: With `sel_n_i`=0 and `gate_n_i`=1 at a clock edge, `dq_oe_o` is all zero and `standby_o` is 0 after that edge.
- R5: In 8-bit organisation (`org_word_i`=0), `dq_o[7:0]` carries bits [7:0] of the entry when `top_pin_i`=0 and bits [15:8] when `top_pin_i`=1.
- R6: In 8-bit organisation, `dq_oe_o[15:8]` is zero and `dq_o[15:8]` is zero. `dq_oe_o[7:0]` is all ones when select and gate are both low.
- R7: Outputs change at the first clock edge after an input change, and not before that edge.
- R8: While `sel_n_i`=1, `dq_o` holds the last fetched value, because no array access takes place.
- R9: During reset (`rst_n`=0), `dq_o`=0, `dq_oe_o`=0 and `standby_o`=1. Reset takes effect without waiting for a clock edge.
- R10: In 16-bit organisation, `top_pin_i` has no effect on `dq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 20 | Entry address |
| sel_n_i | input | 1 | Active-low device select; high means standby |
| gate_n_i | input | 1 | Active-low output gate |
| org_word_i | input | 1 | 1 selects 16-bit organisation, 0 selects 8-bit |
| top_pin_i | input | 1 | Level on the shared top pin; the low address bit in 8-bit organisation |
| dq_o | output | 16 | Data outputs |
| dq_oe_o | output | 16 | Tri-state enable for each data output |
| standby_o | output | 1 | Device deselected, no fetch |

## Verification
The bench builds the block with its defaults: a 20-bit address, 16-bit data and key 16'h5A3C. With these values the address folds into two 16-bit chunks, so the top address nibble reaches the low data bits. The all-zero and all-ones addresses therefore expose both the key and the fold. The 16-bit data width gives 8-bit lanes, so each half-select lands on a distinct byte pattern, and the floated upper lane can be seen against the driven lower lane.

// File: rtl/otp_rd_pkg.sv
package otp_rd_pkg;

  typedef enum logic {
    ORG_BYTE = 1'b0,
    ORG_WORD = 1'b1
  } org_e;

  typedef struct packed {
    org_e org;
    logic upper;
  } lane_req_t;

endpackage

// File: rtl/otp_array_model.sv
module otp_array_model #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] KEY = 16'h5A3C
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] entry
);

  localparam int NCH  = (ADDR_W + DATA_W - 1) / DATA_W;
  localparam int PADW = NCH * DATA_W;

  logic [PADW-1:0]   apad;
  logic [DATA_W-1:0] fold [NCH+1];

  assign apad    = PADW'(addr);
  assign fold[0] = KEY;

  for (genvar g = 0; g < NCH; g++) begin : g_fold
    assign fold[g+1] = fold[g] ^ apad[g*DATA_W +: DATA_W];
  end

  assign entry = fold[NCH];

endmodule

// File: rtl/otp_lane_sel.sv
module otp_lane_sel
  import otp_rd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] entry,
  input  lane_req_t         req,
  output logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] mask
);

  localparam int LANE_W = DATA_W / 2;

  logic [LANE_W-1:0] lane;

  always_comb begin
    lane = req.upper ? entry[DATA_W-1 -: LANE_W] : entry[LANE_W-1:0];
    if (req.org == ORG_WORD) begin
      data = entry;
      mask = '1;
    end else begin
      data = {{LANE_W{1'b0}}, lane};
      mask = {{LANE_W{1'b0}}, {LANE_W{1'b1}}};
    end
  end

endmodule

// File: rtl/otp_out_stage.sv
module otp_out_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_en,
  input  logic              drive_en,
  input  logic [DATA_W-1:0] nxt_data,
  input  logic [DATA_W-1:0] nxt_mask,
  output logic [DATA_W-1:0] dq,
  output logic [DATA_W-1:0] dq_oe,
  output logic              standby
);

  logic [DATA_W-1:0] data_q, data_d;
  logic [DATA_W-1:0] oe_q, oe_d;
  logic              sb_q, sb_d;

  always_comb begin
    data_d = fetch_en ? nxt_data : data_q;
    oe_d   = drive_en ? nxt_mask : '0;
    sb_d   = ~fetch_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      oe_q   <= '0;
      sb_q   <= 1'b1;
    end else begin
      data_q <= data_d;
      oe_q   <= oe_d;
      sb_q   <= sb_d;
    end
  end

  assign dq      = data_q;
  assign dq_oe   = oe_q;
  assign standby = sb_q;

endmodule

// File: rtl/otp_rd_port.sv
module otp_rd_port
  import otp_rd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] KEY = 16'h5A3C,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sel_n_i,
  input  logic              gate_n_i,
  input  logic              org_word_i,
  input  logic              top_pin_i,
  output logic [DATA_W-1:0] dq_o,
  output logic [DATA_W-1:0] dq_oe_o,
  output logic              standby_o
);

  logic [SYNC_STAGES-1:0] rst_chain;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain <= '0;
    else        rst_chain <= {rst_chain[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_chain[SYNC_STAGES-1];

  lane_req_t         req;
  logic [DATA_W-1:0] entry;
  logic [DATA_W-1:0] sel_data;
  logic [DATA_W-1:0] sel_mask;
  logic              fetch_en;
  logic              drive_en;

  always_comb begin
    req.org   = org_word_i ? ORG_WORD : ORG_BYTE;
    req.upper = top_pin_i & ~org_word_i;
    fetch_en  = ~sel_n_i;
    drive_en  = ~sel_n_i & ~gate_n_i;
  end

  otp_array_model #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .KEY    (KEY)
  ) u_array (
    .addr  (addr_i),
    .entry (entry)
  );

  otp_lane_sel #(
    .DATA_W (DATA_W)
  ) u_lane (
    .entry (entry),
    .req   (req),
    .data  (sel_data),
    .mask  (sel_mask)
  );

  otp_out_stage #(
    .DATA_W (DATA_W)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .fetch_en (fetch_en),
    .drive_en (drive_en),
    .nxt_data (sel_data),
    .nxt_mask (sel_mask),
    .dq       (dq_o),
    .dq_oe    (dq_oe_o),
    .standby  (standby_o)
  );

endmodule

// File: rtl/otp_rd_port_chk.sv
module otp_rd_port_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_q,
  input logic              sel_n_i,
  input logic              gate_n_i,
  input logic              org_word_i,
  input logic [DATA_W-1:0] dq_o,
  input logic [DATA_W-1:0] dq_oe_o,
  input logic              standby_o
);

  localparam int LANE_W = DATA_W / 2;

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= rst_q;
  end

  p_word_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!sel_n_i && !gate_n_i && org_word_i) |-> (dq_oe_o == '1));

  p_desel_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(sel_n_i) |-> (dq_oe_o == '0) && standby_o);

  p_gate_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!sel_n_i && gate_n_i) |-> (dq_oe_o == '0) && !standby_o);

  p_byte_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!org_word_i) |->
      (dq_oe_o[DATA_W-1:LANE_W] == '0) && (dq_o[DATA_W-1:LANE_W] == '0));

  p_byte_low_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!sel_n_i && !gate_n_i && !org_word_i) |->
      (dq_oe_o[LANE_W-1:0] == '1));

  p_standby_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(sel_n_i) |-> $stable(dq_o));

endmodule

bind otp_rd_port otp_rd_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_q      (rst_sync_n),
  .sel_n_i    (sel_n_i),
  .gate_n_i   (gate_n_i),
  .org_word_i (org_word_i),
  .dq_o       (dq_o),
  .dq_oe_o    (dq_oe_o),
  .standby_o  (standby_o)
);

// File: tb/test_otp_rd_port.sv
module test_otp_rd_port;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] KEY = 16'h5A3C;

  logic        clk;
  logic        rst_n;
  logic [19:0] addr_i;
  logic        sel_n_i, gate_n_i, org_word_i, top_pin_i;
  logic [15:0] dq_o, dq_oe_o;
  logic        standby_o;

  int checks;
  int errors;
  bit done;

  otp_rd_port i_otp_rd_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr_i),
    .sel_n_i    (sel_n_i),
    .gate_n_i   (gate_n_i),
    .org_word_i (org_word_i),
    .top_pin_i  (top_pin_i),
    .dq_o       (dq_o),
    .dq_oe_o    (dq_oe_o),
    .standby_o  (standby_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {word, sel_n, gate_n, top, addr[19:0], expected enable mask[15:0]}
  localparam int NV = 12;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 20'h00000, 16'hFFFF},
    {1'b1, 1'b0, 1'b0, 1'b1, 20'h12345, 16'hFFFF},
    {1'b1, 1'b0, 1'b0, 1'b0, 20'hFFFFF, 16'hFFFF},
    {1'b1, 1'b0, 1'b1, 1'b0, 20'hABCDE, 16'h0000},
    {1'b1, 1'b1, 1'b0, 1'b0, 20'h55555, 16'h0000},
    {1'b0, 1'b0, 1'b0, 1'b0, 20'h0F0F0, 16'h00FF},
    {1'b0, 1'b0, 1'b0, 1'b1, 20'h0F0F0, 16'h00FF},
    {1'b0, 1'b0, 1'b0, 1'b1, 20'hFFFFF, 16'h00FF},
    {1'b0, 1'b1, 1'b1, 1'b1, 20'h33333, 16'h0000},
    {1'b0, 1'b0, 1'b1, 1'b0, 20'h80001, 16'h0000},
    {1'b1, 1'b1, 1'b1, 1'b0, 20'h00001, 16'h0000},
    {1'b1, 1'b0, 1'b0, 1'b1, 20'hA5A5A, 16'hFFFF}
  };

  function automatic logic [15:0] entry_of(logic [19:0] a);
    return KEY ^ a[15:0] ^ {12'h000, a[19:16]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(logic w, logic s, logic g, logic t, logic [19:0] a);
    @(negedge clk);
    org_word_i = w;
    sel_n_i    = s;
    gate_n_i   = g;
    top_pin_i  = t;
    addr_i     = a;
  endtask

  task automatic settle();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] exp_data;
    logic [15:0] e;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0;
    org_word_i = 1'b1; sel_n_i = 1'b0; gate_n_i = 1'b0; top_pin_i = 1'b0;
    addr_i = 20'h12345;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    // R9: reset state, even though the inputs request a drive
    check("R9", dq_oe_o, 16'h0000);
    check("R9", dq_o, 16'h0000);
    check("R9", standby_o, 1);

    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    exp_data = 16'h0000;
    for (int i = 0; i < NV; i++) begin
      logic        w, s, g, t;
      logic [19:0] a;
      logic [15:0] m;
      {w, s, g, t, a, m} = VEC[i];
      drive(w, s, g, t, a);
      settle();
      e = entry_of(a);
      if (!s) exp_data = w ? e : {8'h00, (t ? e[15:8] : e[7:0])};
      if (s)       check("R8", dq_o, exp_data);
      else if (w)  check("R1", dq_o, exp_data);
      else         check("R5", dq_o, exp_data);
      if (s)       check("R3", dq_oe_o, m);
      else if (g)  check("R4", dq_oe_o, m);
      else if (w)  check("R2", dq_oe_o, m);
      else         check("R6", dq_oe_o, m);
      check(s ? "R3" : "R4", standby_o, s);
    end

    // R10: toggling the shared pin in 16-bit organisation
    drive(1'b1, 1'b0, 1'b0, 1'b0, 20'h2468A);
    settle();
    check("R10", dq_o, entry_of(20'h2468A));
    drive(1'b1, 1'b0, 1'b0, 1'b1, 20'h2468A);
    settle();
    check("R10", dq_o, entry_of(20'h2468A));

    // R7: new address visible only after the next edge
    drive(1'b1, 1'b0, 1'b0, 1'b0, 20'h13579);
    #1;
    check("R7", dq_o, entry_of(20'h2468A));
    settle();
    check("R7", dq_o, entry_of(20'h13579));

    // R6: upper lane stays zero and floated in 8-bit organisation
    drive(1'b0, 1'b0, 1'b0, 1'b1, 20'hFFFF0);
    settle();
    e = entry_of(20'hFFFF0);
    check("R6", dq_o[15:8], 8'h00);
    check("R5", dq_o[7:0], e[15:8]);

    // R8: standby across several cycles with moving address
    drive(1'b1, 1'b1, 1'b0, 1'b0, 20'h00F00);
    settle();
    drive(1'b1, 1'b1, 1'b0, 1'b0, 20'h0F000);
    settle();
    check("R8", dq_o, {8'h00, e[15:8]});
    check("R3", standby_o, 1);

    // R9: asynchronous reset mid-cycle while driving
    drive(1'b1, 1'b0, 1'b0, 1'b0, 20'h77777);
    settle();
    check("R2", dq_oe_o, 16'hFFFF);
    #1 rst_n = 1'b0;
    #1;
    check("R9", dq_oe_o, 16'h0000);
    check("R9", standby_o, 1);

    finish_run();
  end

endmodule